// File: doc/BRIEF.md
# LCD Panel Sync Timing Generator

This block produces the raster timing for an LCD panel: vertical sync, horizontal sync, a data-valid strobe and the current column and row positions. It runs on the system clock and moves forward by one dot-clock period each time the pixel-clock enable is high. Between enables every output holds its value, so the pixel pipeline downstream can use the strobes without a second clock.

A line has five parts, in this order: a lead-in that sets the delay from the vertical sync edge to horizontal sync, the horizontal sync pulse, a back porch, the active pixels and a front porch. A frame is a list of such lines. In TFT mode the frame has sync rows, back-porch rows, active rows and front-porch rows. In STN mode every row is active, and vertical sync covers one full line that starts at the first active dot of that line.

All timing fields are sampled together at the start of each frame. A frame that is already running keeps its timing. When the same sample is taken, the block checks whether the datapath has enough lead time before the first valid pixel and raises an error flag if it does not.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset `hsyncO`, `vsyncO`, `dataEnO`, `cfgErrO`, `colO` and `rowO` are all 0, and they stay 0 until the first cycle with `pixEn` high. That cycle starts a frame at column 0, row 0.
- R2: `colO` and `rowO` change only on cycles with `pixEn` high. `colO` counts from 0 to L-1, where L = vhDelay+hsWidth+hBack+actCols+hFront+5, and then returns to 0 while `rowO` increments. At the end of the last row of a frame both counters return to 0.
- R3: `hsyncO` is high for hsWidth+1 dot periods in every line, starting at column vhDelay+1. Measured from the start of a line, which is also where vertical sync falls, the gap before horizontal sync is vhDelay+1 dot periods.
- R4: `dataEnO` is high for actCols+1 dot periods in every active row. It rises hBack+1 dot periods after `hsyncO` falls.
- R5: From the fall of `dataEnO` to the next rise of `hsyncO` there are hFront+vhDelay+2 dot periods.
- R6: TFT mode (`stnMode`=0). `vsyncO` is high for rows 0 to vsWidth. The next vBack rows are inactive. Then come actRows+1 active rows and finally vFront inactive rows. No +1 offset applies to either vertical porch.
- R7: STN mode (`stnMode`=1). Every row is active, and vsWidth, vBack and vFront have no effect. `vsyncO` rises at the first active column of row 0 and falls at the first active column of row 1.
- R8: All configuration inputs, the mode included, are sampled only at the start of a frame. Changing them in the middle of a frame leaves that frame unchanged.
- R9: `cfgErrO` is updated at each frame start. It is set to 1 if (vhDelay+hsWidth+hBack+3)*dotDiv < DPATH_LAT or if actCols is 0, and to 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| pixEn | input | 1 | Pixel-clock enable; one high cycle marks one dot period |
| stnMode | input | 1 | 1 = STN panel, 0 = TFT panel |
| vhDelay | input | 8 | Vertical-to-horizontal delay field (delay = field+1) |
| hsWidth | input | 8 | Horizontal sync width field (width = field+1) |
| hBack | input | 8 | Horizontal back porch field (length = field+1) |
| hFront | input | 8 | Horizontal front porch field |
| vsWidth | input | 6 | Vertical sync width field, in lines (field+1) |
| vBack | input | 6 | Vertical back porch, in lines |
| vFront | input | 6 | Vertical front porch, in lines |
| actCols | input | 10 | Active dots per line minus one |
| actRows | input | 10 | Active rows per frame minus one |
| dotDiv | input | 6 | Pixel-clock period in system clocks, used for the latency check |
| hsyncO | output | 1 | Horizontal sync |
| vsyncO | output | 1 | Vertical sync |
| dataEnO | output | 1 | Data-valid strobe |
| colO | output | 12 | Current column within the line |
| rowO | output | 11 | Current row within the frame |
| cfgErrO | output | 1 | Latency or size error in the sampled configuration |

## Verification
Every output is decoded from registers that change on the rising clock edge where `pixEn` is sampled high. A dot step therefore shows up on all outputs in that same cycle. The bench drives the enable at the falling edge and compares at the next falling edge, half a period after the update. The error flag and any new configuration take effect on the edge that opens a frame, never earlier, so the reference model takes its own configuration sample only on that tick. The front-porch gap of R5 is measured separately by counting dot ticks between the two edges.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  localparam int HFLD_W = 8;
  localparam int VFLD_W = 6;
  localparam int HOZ_W  = 10;
  localparam int ROW_W  = 10;
  localparam int DIV_W  = 6;

  // widest line: four horizontal fields, the active count and the fixed offsets
  localparam int HCNT_W = $clog2(4 * ((1 << HFLD_W) - 1) + ((1 << HOZ_W) - 1) + 6);
  // tallest frame: three vertical fields, the active rows and the fixed offsets
  localparam int VCNT_W = $clog2(3 * ((1 << VFLD_W) - 1) + ((1 << ROW_W) - 1) + 3);

  typedef struct packed {
    logic              stnMode;
    logic [HFLD_W-1:0] vhDelay;
    logic [HFLD_W-1:0] hsWidth;
    logic [HFLD_W-1:0] hBack;
    logic [HFLD_W-1:0] hFront;
    logic [VFLD_W-1:0] vsWidth;
    logic [VFLD_W-1:0] vBack;
    logic [VFLD_W-1:0] vFront;
    logic [HOZ_W-1:0]  actCols;
    logic [ROW_W-1:0]  actRows;
    logic [DIV_W-1:0]  dotDiv;
  } timing_cfg_t;

  typedef struct packed {
    logic active;   // first dot tick seen since reset
    logic load;     // frame origin: sample config, clear both counters
    logic stepCol;  // advance one column
    logic nextRow;  // wrap column, advance row
  } seq_strobe_t;

endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixEn,
  input  logic        atLineEnd,
  input  logic        atFrameEnd,
  output seq_strobe_t strb
);

  logic running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (pixEn) begin
      running <= 1'b1;
    end
  end

  always_comb begin
    strb.active  = running;
    strb.load    = pixEn && (!running || (atLineEnd && atFrameEnd));
    strb.nextRow = pixEn && running && atLineEnd && !atFrameEnd;
    strb.stepCol = pixEn && running && !atLineEnd;
  end

  // R2: the three sequencing actions never coincide
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.stepCol, strb.nextRow}));

  // R1: the first dot tick after reset opens a frame
  p_first_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!running && pixEn) |=> running);

  // R2: with no enable, no counter action is requested
  p_no_tick_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |-> !(strb.load || strb.stepCol || strb.nextRow));

endmodule

// File: rtl/lcdt_dpath.sv
module lcdt_dpath
  import lcdt_pkg::*;
#(
  parameter int DPATH_LAT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  timing_cfg_t       cfgIn,
  input  seq_strobe_t       strb,
  output logic              atLineEnd,
  output logic              atFrameEnd,
  output logic              hsyncO,
  output logic              vsyncO,
  output logic              dataEnO,
  output logic [HCNT_W-1:0] colO,
  output logic [VCNT_W-1:0] rowO,
  output logic              cfgErrO
);

  localparam int PROD_W = HCNT_W + DIV_W;

  // position counters
  logic [HCNT_W-1:0] hPos;
  logic [VCNT_W-1:0] vPos;

  // boundaries latched at frame start
  logic              stnR;
  logic [HCNT_W-1:0] hsStartR, hsEndR, actStartR, actEndR, lineLastR;
  logic [VCNT_W-1:0] vsEndR, rowStartR, rowEndR, frameLastR;
  logic              cfgErrR;

  // next-frame boundaries from the live configuration
  logic [HCNT_W-1:0] hsStartN, hsEndN, actStartN, actEndN, lineLastN;
  logic [VCNT_W-1:0] vsEndN, rowStartN, rowEndN, frameLastN;
  logic [PROD_W-1:0] leadProd;
  logic              cfgErrN;

  always_comb begin
    hsStartN  = HCNT_W'(cfgIn.vhDelay) + HCNT_W'(1);
    hsEndN    = hsStartN + HCNT_W'(cfgIn.hsWidth) + HCNT_W'(1);
    actStartN = hsEndN + HCNT_W'(cfgIn.hBack) + HCNT_W'(1);
    actEndN   = actStartN + HCNT_W'(cfgIn.actCols) + HCNT_W'(1);
    lineLastN = actEndN + HCNT_W'(cfgIn.hFront);

    vsEndN = VCNT_W'(cfgIn.vsWidth) + VCNT_W'(1);
    if (cfgIn.stnMode) begin
      rowStartN  = '0;
      rowEndN    = VCNT_W'(cfgIn.actRows) + VCNT_W'(1);
      frameLastN = VCNT_W'(cfgIn.actRows);
    end else begin
      rowStartN  = vsEndN + VCNT_W'(cfgIn.vBack);
      rowEndN    = rowStartN + VCNT_W'(cfgIn.actRows) + VCNT_W'(1);
      frameLastN = rowEndN + VCNT_W'(cfgIn.vFront) - VCNT_W'(1);
    end

    // lead time before the first valid dot, in system clocks
    leadProd = PROD_W'(actStartN) * PROD_W'(cfgIn.dotDiv);
    cfgErrN  = (leadProd < PROD_W'(DPATH_LAT)) || (cfgIn.actCols == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stnR       <= 1'b0;
      hsStartR   <= '0;
      hsEndR     <= '0;
      actStartR  <= '0;
      actEndR    <= '0;
      lineLastR  <= '0;
      vsEndR     <= '0;
      rowStartR  <= '0;
      rowEndR    <= '0;
      frameLastR <= '0;
      cfgErrR    <= 1'b0;
    end else if (strb.load) begin
      stnR       <= cfgIn.stnMode;
      hsStartR   <= hsStartN;
      hsEndR     <= hsEndN;
      actStartR  <= actStartN;
      actEndR    <= actEndN;
      lineLastR  <= lineLastN;
      vsEndR     <= vsEndN;
      rowStartR  <= rowStartN;
      rowEndR    <= rowEndN;
      frameLastR <= frameLastN;
      cfgErrR    <= cfgErrN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hPos <= '0;
      vPos <= '0;
    end else if (strb.load) begin
      hPos <= '0;
      vPos <= '0;
    end else if (strb.nextRow) begin
      hPos <= '0;
      vPos <= vPos + VCNT_W'(1);
    end else if (strb.stepCol) begin
      hPos <= hPos + HCNT_W'(1);
    end
  end

  logic inRowAct, inColAct, vsRaw;

  always_comb begin
    atLineEnd  = (hPos == lineLastR);
    atFrameEnd = (vPos == frameLastR);
    inRowAct   = (vPos >= rowStartR) && (vPos < rowEndR);
    inColAct   = (hPos >= actStartR) && (hPos < actEndR);
    if (stnR) begin
      vsRaw = ((vPos == '0) && (hPos >= actStartR)) ||
              ((vPos == VCNT_W'(1)) && (hPos < actStartR));
    end else begin
      vsRaw = (vPos < vsEndR);
    end
    hsyncO  = strb.active && (hPos >= hsStartR) && (hPos < hsEndR);
    dataEnO = strb.active && inRowAct && inColAct;
    vsyncO  = strb.active && vsRaw;
    colO    = hPos;
    rowO    = vPos;
    cfgErrO = cfgErrR;
  end

  // R2: column never passes the latched line end
  p_col_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.active |-> (hPos <= lineLastR));

  // R2: counters hold when no sequencing action occurs
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.stepCol || strb.nextRow) |=> ($stable(hPos) && $stable(vPos)));

  // R4: valid data never overlaps horizontal sync
  p_de_clear_of_sync_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataEnO |-> !hsyncO);

  // R8: a frame start returns the raster to its origin
  p_load_origin_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (hPos == '0) && (vPos == '0));

  // R1: nothing is driven before the first dot tick
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |-> !(hsyncO || vsyncO || dataEnO));

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcdt_pkg::*;
#(
  parameter int DPATH_LAT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixEn,
  input  logic              stnMode,
  input  logic [HFLD_W-1:0] vhDelay,
  input  logic [HFLD_W-1:0] hsWidth,
  input  logic [HFLD_W-1:0] hBack,
  input  logic [HFLD_W-1:0] hFront,
  input  logic [VFLD_W-1:0] vsWidth,
  input  logic [VFLD_W-1:0] vBack,
  input  logic [VFLD_W-1:0] vFront,
  input  logic [HOZ_W-1:0]  actCols,
  input  logic [ROW_W-1:0]  actRows,
  input  logic [DIV_W-1:0]  dotDiv,
  output logic              hsyncO,
  output logic              vsyncO,
  output logic              dataEnO,
  output logic [HCNT_W-1:0] colO,
  output logic [VCNT_W-1:0] rowO,
  output logic              cfgErrO
);

  timing_cfg_t cfgBus;
  seq_strobe_t strb;
  logic        atLineEnd, atFrameEnd;

  always_comb begin
    cfgBus.stnMode = stnMode;
    cfgBus.vhDelay = vhDelay;
    cfgBus.hsWidth = hsWidth;
    cfgBus.hBack   = hBack;
    cfgBus.hFront  = hFront;
    cfgBus.vsWidth = vsWidth;
    cfgBus.vBack   = vBack;
    cfgBus.vFront  = vFront;
    cfgBus.actCols = actCols;
    cfgBus.actRows = actRows;
    cfgBus.dotDiv  = dotDiv;
  end

  lcdt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pixEn      (pixEn),
    .atLineEnd  (atLineEnd),
    .atFrameEnd (atFrameEnd),
    .strb       (strb)
  );

  lcdt_dpath #(.DPATH_LAT(DPATH_LAT)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgIn      (cfgBus),
    .strb       (strb),
    .atLineEnd  (atLineEnd),
    .atFrameEnd (atFrameEnd),
    .hsyncO     (hsyncO),
    .vsyncO     (vsyncO),
    .dataEnO    (dataEnO),
    .colO       (colO),
    .rowO       (rowO),
    .cfgErrO    (cfgErrO)
  );

endmodule

// File: tb/sim_lcd_sync_gen.sv
`timescale 1ns/1ps
module sim_lcd_sync_gen;
  import lcdt_pkg::*;

  localparam int LAT = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN, pixEn, stnMode;
  logic [HFLD_W-1:0] vhDelay, hsWidth, hBack, hFront;
  logic [VFLD_W-1:0] vsWidth, vBack, vFront;
  logic [HOZ_W-1:0]  actCols;
  logic [ROW_W-1:0]  actRows;
  logic [DIV_W-1:0]  dotDiv;
  logic              hsyncO, vsyncO, dataEnO, cfgErrO;
  logic [HCNT_W-1:0] colO;
  logic [VCNT_W-1:0] rowO;

  lcd_sync_gen #(.DPATH_LAT(LAT)) u0 (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .stnMode(stnMode),
    .vhDelay(vhDelay), .hsWidth(hsWidth), .hBack(hBack), .hFront(hFront),
    .vsWidth(vsWidth), .vBack(vBack), .vFront(vFront),
    .actCols(actCols), .actRows(actRows), .dotDiv(dotDiv),
    .hsyncO(hsyncO), .vsyncO(vsyncO), .dataEnO(dataEnO),
    .colO(colO), .rowO(rowO), .cfgErrO(cfgErrO)
  );

  int    nRun = 0, nFail = 0, cyc = 0;
  bit    done = 0;
  string note = "";

  // reference model state
  int mRun, mh, mv, mErr;
  int sStn, sVh, sHp, sHb, sHf, sHz, sVp, sVb, sVf, sLv;

  function automatic int lineLen();
    return sVh + sHp + sHb + sHz + sHf + 5;
  endfunction

  function automatic int frameLines();
    return sStn ? sLv + 1 : sVp + sVb + sLv + sVf + 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mh = 0; mv = 0; mErr = 0;
      sStn = 0; sVh = 0; sHp = 0; sHb = 0; sHf = 0; sHz = 0;
      sVp = 0; sVb = 0; sVf = 0; sLv = 0;
    end else if (pixEn) begin
      if (!mRun || (mh == lineLen() - 1 && mv == frameLines() - 1)) begin
        sStn = int'(stnMode); sVh = int'(vhDelay); sHp = int'(hsWidth);
        sHb = int'(hBack); sHf = int'(hFront); sHz = int'(actCols);
        sVp = int'(vsWidth); sVb = int'(vBack); sVf = int'(vFront);
        sLv = int'(actRows);
        mErr = (((sVh + sHp + sHb + 3) * int'(dotDiv)) < LAT || sHz == 0) ? 1 : 0;
        mh = 0; mv = 0; mRun = 1;
      end else if (mh == lineLen() - 1) begin
        mh = 0; mv++;
      end else begin
        mh++;
      end
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s%s %s: actual=%0d expected=%0d (t=%0t)", tag, note, nm, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      nFail++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      finishRun();
    end
  end

  bit genOn = 0, jitter = 0;
  int divCnt = 0, gap = 0;
  bit gapOk = 0, prevDe = 0, prevHs = 0;

  task automatic step();
    int aS;
    int eHs, eDe, eVs, rowAct;
    bit lastTick;
    @(negedge clk);
    lastTick = pixEn;
    aS = sVh + sHp + sHb + 3;
    eHs = (mRun && mh >= sVh + 1 && mh <= sVh + sHp + 1) ? 1 : 0;
    rowAct = sStn ? 1 : ((mv >= sVp + 1 + sVb && mv <= sVp + sVb + sLv + 1) ? 1 : 0);
    eDe = (mRun && rowAct && mh >= aS && mh <= aS + sHz) ? 1 : 0;
    if (sStn) eVs = (mRun && ((mv == 0 && mh >= aS) || (mv == 1 && mh < aS))) ? 1 : 0;
    else      eVs = (mRun && mv <= sVp) ? 1 : 0;
    if (!mRun) begin
      chk("R1", "hsync", int'(hsyncO), 0);
      chk("R1", "vsync", int'(vsyncO), 0);
      chk("R1", "dataEn", int'(dataEnO), 0);
      chk("R1", "col", int'(colO), 0);
      chk("R1", "row", int'(rowO), 0);
      chk("R1", "cfgErr", int'(cfgErrO), 0);
    end else begin
      chk("R3", "hsync", int'(hsyncO), eHs);
      chk(sStn ? "R7" : "R6", "vsync", int'(vsyncO), eVs);
      chk("R4", "dataEn", int'(dataEnO), eDe);
      chk("R2", "col", int'(colO), mh);
      chk("R2", "row", int'(rowO), mv);
      chk("R9", "cfgErr", int'(cfgErrO), mErr);
    end
    // front-porch gap in dot ticks
    if (lastTick && mRun) begin
      if (mh == 0 && mv == 0) gapOk = 0;
      if (prevDe && !dataEnO) begin
        gap = 0; gapOk = 1;
      end else if (gapOk) begin
        gap++;
      end
      if (!prevHs && hsyncO && gapOk) begin
        chk("R5", "de-fall to hsync-rise gap", gap, sHf + sVh + 2);
        gapOk = 0;
      end
      prevDe = dataEnO; prevHs = hsyncO;
    end
    // drive next enable
    if (!genOn) begin
      pixEn = 1'b0;
    end else if (jitter) begin
      pixEn = ($urandom_range(0, 2) == 0);
    end else begin
      pixEn = (divCnt == 0);
      divCnt = (divCnt + 1 >= int'(dotDiv)) ? 0 : divCnt + 1;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic doReset();
    genOn = 0; rstN = 1'b0; divCnt = 0; gapOk = 0; prevDe = 0; prevHs = 0;
    run(3);
    rstN = 1'b1;
    run(3);
    genOn = 1;
  endtask

  task automatic setCfg(int stn, int vh, int hp, int hb, int hf, int hz,
                        int vp, int vb, int vf, int lv, int dv);
    stnMode = 1'(stn);
    vhDelay = HFLD_W'(vh); hsWidth = HFLD_W'(hp);
    hBack = HFLD_W'(hb); hFront = HFLD_W'(hf);
    actCols = HOZ_W'(hz);
    vsWidth = VFLD_W'(vp); vBack = VFLD_W'(vb); vFront = VFLD_W'(vf);
    actRows = ROW_W'(lv);
    dotDiv = DIV_W'(dv);
  endtask

  initial begin
    rstN = 1'b0; pixEn = 1'b0;
    // TFT with porches on both axes, divide by 3, latency met (R6, R3, R4, R5, R9)
    setCfg(0, 1, 2, 1, 2, 7, 1, 2, 1, 3, 3);
    doReset();
    run(1100);
    // TFT minimal fields, zero vertical porches, enable every cycle: latency short (R9)
    setCfg(0, 0, 0, 0, 0, 1, 0, 0, 0, 2, 1);
    doReset();
    run(300);
    // STN: vertical fields must be ignored (R7)
    setCfg(1, 2, 1, 1, 1, 4, 3, 2, 2, 2, 2);
    doReset();
    run(300);
    // mid-frame change is deferred to the next frame (R8)
    setCfg(0, 1, 2, 1, 2, 7, 1, 2, 1, 3, 2);
    doReset();
    run(100);
    note = "/R8";
    setCfg(1, 2, 1, 1, 1, 4, 3, 2, 2, 2, 2);
    run(700);
    note = "";
    // one active dot per line flags an error; irregular enable pattern (R9, R2)
    jitter = 1;
    setCfg(0, 2, 2, 2, 1, 0, 0, 1, 1, 1, 5);
    doReset();
    run(400);
    jitter = 0;
    finishRun();
  end

endmodule